// File: doc/BRIEF.md
# Packet FIFO Interrupt Status and Enable Bank

This block holds the interrupt bookkeeping for a memory-mapped packet FIFO. Four single-cycle event inputs arrive from the FIFO's channels: a frame has finished leaving the transmit side, a frame has been fully taken in on the receive side, a transmit-side reset has finished, and a receive-side reset has finished. Each event latches a sticky bit in a status register. A separate enable register selects which latched events may raise the single level-sensitive interrupt output.

Software reaches the bank through a plain word-addressed port with a write strobe, a write data bus and a combinational read data bus. The status register is cleared by writing ones to the bits to be cleared. The enable register is a plain read/write register. A read-only pending view returns the AND of status and enable. Status can be polled whether or not any interrupt is enabled.

The four event bits sit side by side in the data word, starting at bit `EVT_LSB`. From the LSB of that group upward they are: transmit frame done, receive frame done, transmit reset done, receive reset done. No other bit can be written, and all other bits read as zero.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset the status register, the enable register and `irq` are all zero.
- R2: A high event input sets its status bit (transmit done at `EVT_LSB`, receive done at `EVT_LSB+1`, transmit reset done at `EVT_LSB+2`, receive reset done at `EVT_LSB+3`) on the next rising clock edge. The bit can be read at word address 0 whatever the enable register holds.
- R3: A write to word address 0 clears every status bit written as 1 and leaves every status bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit is set after the edge.
- R5: A write to word address 1 loads the enable register with the write data restricted to the event bits. Reading address 1 returns that value.
- R6: Reading word address 2 returns the bitwise AND of status and enable.
- R7: `irq` is a registered output equal to the OR of all pending bits. It changes on the same edge as the status or enable change that causes it, which is one cycle after the event or write.
- R8: Bits outside the four event positions read as zero at addresses 0, 1 and 2. Writing ones to those positions changes nothing.
- R9: Addresses other than 0, 1 and 2 read as zero, and writes to them change neither register.
- R10: Status changes only through events or writes to address 0. Address 2 is read-only, and writes to it or to address 1 leave status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| evt_tx_done | input | 1 | Transmit frame finished |
| evt_rx_done | input | 1 | Receive frame complete |
| evt_tx_rst_done | input | 1 | Transmit reset finished |
| evt_rx_rst_done | input | 1 | Receive reset finished |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the bank with `EVT_LSB` set to 3, with a 32-bit data word and a 4-bit address. This puts masked-off bits on both sides of the event group: bits 0 to 2 below it and bits 7 up to 31 above it. With that placement, an off-by-one or unshifted mask shows up in the read data, and a write of all ones to the status or enable address shows whether stray bits leak through. The 4-bit address leaves thirteen unmapped words, and the bench reads and writes them to confirm that they decode to nothing.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    // number of event sources and their order inside the event group
    localparam int unsigned EVT_N         = 4;
    localparam int unsigned EV_TX_DONE    = 0;
    localparam int unsigned EV_RX_DONE    = 1;
    localparam int unsigned EV_TX_RST     = 2;
    localparam int unsigned EV_RX_RST     = 3;

    // word offsets of the three visible registers
    localparam int unsigned OFS_STATUS    = 0;
    localparam int unsigned OFS_ENABLE    = 1;
    localparam int unsigned OFS_PENDING   = 2;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_ENABLE  = 2'd2,
        SEL_PENDING = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              wr_status,
    output logic              wr_enable
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_STATUS))       sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFS_ENABLE))  sel = SEL_ENABLE;
        else if (addr == ADDR_W'(OFS_PENDING)) sel = SEL_PENDING;
    end

    // the pending view is read-only, so no strobe is produced for it
    assign wr_status = wr_en && (sel == SEL_STATUS);
    assign wr_enable = wr_en && (sel == SEL_ENABLE);

endmodule

// File: rtl/irqb_status.sv
module irqb_status
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EVT_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_N-1:0]  evt,
    output logic [DATA_W-1:0] st_q,
    output logic [DATA_W-1:0] st_d
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'({EVT_N{1'b1}}) << EVT_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } st_t;

    st_t cur_q, nxt_d;
    logic [DATA_W-1:0] set_vec;

    // place each event at its bit inside the data word
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < int'(EVT_N); i++) begin
            set_vec[EVT_LSB + i] = evt[i];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (clr_wr) begin
            nxt_d.bits = nxt_d.bits & ~(wdata & MASK);
        end
        // a new event is applied after the clear so it wins a collision
        nxt_d.bits = (nxt_d.bits | set_vec) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign st_q = cur_q.bits;
    assign st_d = nxt_d.bits;

endmodule

// File: rtl/irqb_enable.sv
module irqb_enable
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EVT_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] en_d
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'({EVT_N{1'b1}}) << EVT_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } en_t;

    en_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (ld) begin
            nxt_d.bits = wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign en_q = cur_q.bits;
    assign en_d = nxt_d.bits;

endmodule

// File: rtl/irqb_readmux.sv
module irqb_readmux
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] st,
    input  logic [DATA_W-1:0] en,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rdata = st;
            SEL_ENABLE:  rdata = en;
            SEL_PENDING: rdata = st & en;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned EVT_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              evt_tx_done,
    input  logic              evt_rx_done,
    input  logic              evt_tx_rst_done,
    input  logic              evt_rx_rst_done,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr_status, wr_enable;
    logic [EVT_N-1:0]  evt_vec;
    logic [DATA_W-1:0] status_q, status_d;
    logic [DATA_W-1:0] enable_q, enable_d;

    always_comb begin
        evt_vec             = '0;
        evt_vec[EV_TX_DONE] = evt_tx_done;
        evt_vec[EV_RX_DONE] = evt_rx_done;
        evt_vec[EV_TX_RST]  = evt_tx_rst_done;
        evt_vec[EV_RX_RST]  = evt_rx_rst_done;
    end

    irqb_decode #(.ADDR_W(ADDR_W)) i_decode (
        .wr_en     (wr_en),
        .addr      (addr),
        .sel       (sel),
        .wr_status (wr_status),
        .wr_enable (wr_enable)
    );

    irqb_status #(.DATA_W(DATA_W), .EVT_LSB(EVT_LSB)) i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_wr (wr_status),
        .wdata  (wdata),
        .evt    (evt_vec),
        .st_q   (status_q),
        .st_d   (status_d)
    );

    irqb_enable #(.DATA_W(DATA_W), .EVT_LSB(EVT_LSB)) i_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr_enable),
        .wdata (wdata),
        .en_q  (enable_q),
        .en_d  (enable_d)
    );

    irqb_readmux #(.DATA_W(DATA_W)) i_readmux (
        .sel   (sel),
        .st    (status_q),
        .en    (enable_q),
        .rdata (rdata)
    );

    // interrupt flop: built from the next register values so it moves
    // on the same edge as the status/enable change behind it
    typedef struct packed {
        logic req;
    } irq_t;

    irq_t irq_q, irq_d;

    always_comb begin
        irq_d     = irq_q;
        irq_d.req = |(status_d & enable_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q.req;

endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned EVT_LSB = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [EVT_N-1:0]  evt,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] enable,
    input logic              irq
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'({EVT_N{1'b1}}) << EVT_LSB;

    logic wr_st, wr_en_reg;
    assign wr_st     = wr_en && (addr == ADDR_W'(OFS_STATUS));
    assign wr_en_reg = wr_en && (addr == ADDR_W'(OFS_ENABLE));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0 && enable == '0 && !irq));

    generate
        for (genvar g = 0; g < int'(EVT_N); g++) begin : g_evt
            // R2 R4
            evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt[g] |=> status[EVT_LSB + g]);
        end
    endgenerate

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && evt == '0) |=> status == ($past(status) & ~($past(wdata) & MASK)));

    // R5
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_reg |=> enable == ($past(wdata) & MASK));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & enable));

    // R8
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~MASK) == '0) && ((enable & ~MASK) == '0));

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_st && evt == '0) |=> $stable(status));

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_reg |=> $stable(enable));

endmodule

bind irq_reg_bank irqb_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .EVT_LSB (EVT_LSB)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .evt    (evt_vec),
    .status (status_q),
    .enable (enable_q),
    .irq    (irq)
);

// File: tb/test_irq_reg_bank.sv
`timescale 1ns/100ps
module test_irq_reg_bank;

    localparam int unsigned DW  = 32;
    localparam int unsigned AW  = 4;
    localparam int unsigned LSB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [3:0]    evt = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    irq_reg_bank #(.DATA_W(DW), .ADDR_W(AW), .EVT_LSB(LSB)) i_irq_reg_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .addr            (addr),
        .wdata           (wdata),
        .rdata           (rdata),
        .evt_tx_done     (evt[0]),
        .evt_rx_done     (evt[1]),
        .evt_tx_rst_done (evt[2]),
        .evt_rx_rst_done (evt[3]),
        .irq             (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  a;
        logic [31:0] wd;
        logic [3:0]  ev;      // bit0 tx done .. bit3 rx reset done
        logic [31:0] st;
        logic [31:0] en;
        logic        iq;
        logic [3:0]  req;     // requirement number for messages
    } vec_t;

    // event group occupies bits 6..3 (mask 0x78)
    localparam vec_t VEC [13] = '{
        '{1'b0, 4'h0, 32'h0,        4'b0001, 32'h08, 32'h00, 1'b0, 4'd2},
        '{1'b1, 4'h1, 32'hFFFFFFFF, 4'b0000, 32'h08, 32'h78, 1'b1, 4'd5},
        '{1'b1, 4'h0, 32'h08,       4'b0010, 32'h10, 32'h78, 1'b1, 4'd3},
        '{1'b1, 4'h0, 32'h10,       4'b0010, 32'h10, 32'h78, 1'b1, 4'd4},
        '{1'b1, 4'h1, 32'h40,       4'b0000, 32'h10, 32'h40, 1'b0, 4'd7},
        '{1'b0, 4'h0, 32'h0,        4'b1000, 32'h50, 32'h40, 1'b1, 4'd2},
        '{1'b1, 4'h0, 32'hFFFFFF87, 4'b0000, 32'h50, 32'h40, 1'b1, 4'd8},
        '{1'b1, 4'h2, 32'hFFFFFFFF, 4'b0000, 32'h50, 32'h40, 1'b1, 4'd10},
        '{1'b1, 4'h5, 32'hFFFFFFFF, 4'b0000, 32'h50, 32'h40, 1'b1, 4'd9},
        '{1'b1, 4'h0, 32'h40,       4'b0000, 32'h10, 32'h40, 1'b0, 4'd3},
        '{1'b0, 4'h0, 32'h0,        4'b0100, 32'h30, 32'h40, 1'b0, 4'd2},
        '{1'b1, 4'h1, 32'hA0,       4'b0000, 32'h30, 32'h20, 1'b1, 4'd5},
        '{1'b1, 4'h0, 32'hFFFFFFFF, 4'b0000, 32'h00, 32'h20, 1'b0, 4'd3}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a;
        #0.2;
        v = rdata;
    endtask

    task automatic apply(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] e);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; evt = e;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic check_regs(input logic [31:0] st, input logic [31:0] en, input logic iq, input string tag);
        logic [DW-1:0] v;
        @(negedge clk);
        rd(AW'(0), v); chk(v == st, {tag, " status"}, v, st);
        rd(AW'(1), v); chk(v == en, {tag, " enable"}, v, en);
        rd(AW'(2), v); chk(v == (st & en), {tag, " R6 pending"}, v, st & en);
        chk(irq == iq, {tag, " R7 irq"}, 32'(irq), 32'(iq));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_regs(32'h0, 32'h0, 1'b0, "R1 reset");

        // vector walk
        foreach (VEC[i]) begin
            apply(VEC[i].wr, VEC[i].a, VEC[i].wd, VEC[i].ev);
            check_regs(VEC[i].st, VEC[i].en, VEC[i].iq, $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R9 unmapped addresses read zero (status and enable are nonzero here)
        apply(1'b0, 4'h0, 32'h0, 4'b0001);
        for (int a = 3; a < 16; a++) begin
            rd(AW'(a), v);
            chk(v == 32'h0, $sformatf("R9 read addr %0d", a), v, 32'h0);
        end

        // R7 timing: enable tx done, clear it, then raise event and watch edges
        apply(1'b1, 4'h1, 32'h08, 4'b0000);
        apply(1'b1, 4'h0, 32'h78, 4'b0000);
        check_regs(32'h00, 32'h08, 1'b0, "R7 pre");
        @(negedge clk);
        evt = 4'b0001;
        #0.2;
        chk(irq == 1'b0, "R7 irq before edge", 32'(irq), 32'h0);
        @(posedge clk);
        #0.5;
        evt = '0;
        chk(irq == 1'b1, "R7 irq after edge", 32'(irq), 32'h1);
        // clearing write drops irq on its edge
        apply(1'b1, 4'h0, 32'h08, 4'b0000);
        chk(irq == 1'b0, "R7 irq drop after clear", 32'(irq), 32'h0);

        // R4 all four events together with a full clear
        apply(1'b1, 4'h0, 32'hFFFFFFFF, 4'b1111);
        check_regs(32'h78, 32'h08, 1'b1, "R4 collision all");

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk(irq == 1'b0, "R1 async reset irq", 32'(irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check_regs(32'h0, 32'h0, 1'b0, "R1 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule